// File: doc/BRIEF.md
# Autonomous Weighted Probabilistic Cell

This block is one stochastic spin of an Ising-style sampling network. It holds a single state bit (1 stands for +1, 0 for -1). It forms a signed input from a few neighbour states, their programmable weights and a programmable bias, and scales that input by a programmable inverse temperature. The scaled input selects an entry of a programmable activation table. A pseudo-random byte compared against that entry sets the new state.

No sequencer chooses which cell moves. Every instance makes an update decision once per programmable synapse period. A programmable attempt probability keeps simultaneous flips of coupled cells rare. The activation table can be written one entry at a time through the cell's own write port. It can also be written through a broadcast port shared by all cells, so that a temperature change during annealing reaches every cell in the same cycle.

Top module: `pbit_cell`

## Requirements
- R1: After reset the state is 0 (-1), all weights and the bias are 0, beta is 4, the attempt threshold is 0, the period register is 0, every table entry is 8'h80 and the generator holds 32'h1D872B41.
- R2: The table index is computed as follows. Sum the bias and, for each neighbour k, +w[k] if nb_i[k] is 1 or -w[k] if it is 0. Multiply the sum by beta (unsigned, two fractional bits) and shift it arithmetically right by 2 (rounding toward minus infinity). Clamp the result to [-32, 31] and add 32.
- R3: On a decision cycle, let A = gen[15:8] and C = gen[7:0]. If A <= attempt threshold, the state becomes 1 when C < table[index] and 0 otherwise. If A is greater than the threshold, the state is kept. The state never changes outside a decision cycle.
- R4: The generator is a right-shifting Galois register. When bit 0 is 1 the shifted value is XORed with 32'h80200003. It steps once per decision, after the decision has used its value. Writing the seed register loads the written value, or 32'h1D872B41 when the value is zero. A seed load takes priority over a step in the same cycle.
- R5: With period register P, decisions occur every max(P,1) run cycles. The first decision after reset happens in the first running cycle.
- R6: While run_i is 0, the state, the generator and the period counter hold. Register writes still take effect.
- R7: A write to address 8'h40+i sets table entry i. A broadcast sets entry bc_idx_i. When both target the same entry in one cycle, the local write wins. A register write reaches the decision in the following cycle.
- R8: The register map is as follows. Weights are at 8'h00..8'h03, data bits [3:0] signed. The bias is at 8'h08, bits [5:0] signed. Beta is at 8'h09, bits [3:0]. The attempt threshold is at 8'h0A, bits [7:0]. The period is at 8'h0B, bits [7:0]. The seed is at 8'h0C, bits [31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 lets the cell evolve, 0 freezes it |
| nb_i | input | 4 | Neighbour states, 1 = +1 |
| wr_en_i | input | 1 | Local register write strobe |
| wr_addr_i | input | 8 | Local register address |
| wr_data_i | input | 32 | Local write data |
| bc_en_i | input | 1 | Broadcast table write strobe |
| bc_idx_i | input | 6 | Broadcast table entry |
| bc_data_i | input | 8 | Broadcast table value |
| state_o | output | 1 | Cell state, 1 = +1 |

## Verification
Sums driven past both clamp limits at maximum beta check the saturation. A design that wrapped instead of clamping would pick the table entry from the far end and flip the opposite way. A zero seed write checks the lock-up guard: without it the generator sticks at zero and the cell attempts on every decision with C = 0. A broadcast and a local write to the same entry check the write priority, because the loser's value would steer later decisions. Pauses held mid-period, period 0 against long periods, and a seed load landing on a decision cycle expose any counter or generator that advances while frozen or steps in the wrong order.

// File: rtl/pbit_pkg.sv
package pbit_pkg;
    localparam int unsigned GEN_W = 32;
    localparam logic [GEN_W-1:0] GEN_TAPS  = 32'h80200003;
    localparam logic [GEN_W-1:0] GEN_SAFE  = 32'h1D872B41;

    localparam logic [7:0] REG_WGT0  = 8'h00;
    localparam logic [7:0] REG_BIAS  = 8'h08;
    localparam logic [7:0] REG_BETA  = 8'h09;
    localparam logic [7:0] REG_ATT   = 8'h0A;
    localparam logic [7:0] REG_PER   = 8'h0B;
    localparam logic [7:0] REG_SEED  = 8'h0C;

    function automatic logic [GEN_W-1:0] gen_advance(input logic [GEN_W-1:0] s);
        logic [GEN_W-1:0] sh;
        sh = s >> 1;
        if (s[0]) sh = sh ^ GEN_TAPS;
        return sh;
    endfunction
endpackage

// File: rtl/pbit_synapse.sv
module pbit_synapse #(
    parameter int NNB       = 4,
    parameter int WGT_W     = 4,
    parameter int BIAS_W    = 6,
    parameter int BETA_W    = 4,
    parameter int BETA_FRAC = 2,
    parameter int IDX_W     = 6
) (
    input  logic [NNB-1:0]        nb_i,
    input  logic [NNB*WGT_W-1:0]  wgt_i,
    input  logic [BIAS_W-1:0]     bias_i,
    input  logic [BETA_W-1:0]     beta_i,
    output logic [IDX_W-1:0]      idx_o
);
    localparam int SUM_W  = WGT_W + BIAS_W + $clog2(NNB + 1);
    localparam int PROD_W = SUM_W + BETA_W + 1;
    localparam int IMAX   = (2 ** (IDX_W - 1)) - 1;
    localparam int IMIN   = -(2 ** (IDX_W - 1));

    logic signed [SUM_W-1:0]  term [NNB];
    logic signed [SUM_W-1:0]  acc;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] clip;

    for (genvar g = 0; g < NNB; g++) begin : g_term
        logic signed [SUM_W-1:0] wext;
        assign wext    = SUM_W'($signed(wgt_i[g*WGT_W +: WGT_W]));
        assign term[g] = nb_i[g] ? wext : -wext;
    end

    always_comb begin
        acc = SUM_W'($signed(bias_i));
        for (int k = 0; k < NNB; k++) begin
            acc = acc + term[k];
        end
        prod   = PROD_W'(acc) * PROD_W'($signed({1'b0, beta_i}));
        scaled = prod >>> BETA_FRAC;
        if (scaled > PROD_W'(IMAX))      clip = PROD_W'(IMAX);
        else if (scaled < PROD_W'(IMIN)) clip = PROD_W'(IMIN);
        else                             clip = scaled;
        idx_o = {~clip[IDX_W-1], clip[IDX_W-2:0]};
    end
endmodule

// File: rtl/pbit_lfsr.sv
module pbit_lfsr
    import pbit_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [GEN_W-1:0] seed_i,
    output logic [GEN_W-1:0] value_o
);
    logic [GEN_W-1:0] gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (load_i)      gen_d = (seed_i == '0) ? GEN_SAFE : seed_i;
        else if (step_i) gen_d = gen_advance(gen_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gen_q <= GEN_SAFE;
        else         gen_q <= gen_d;
    end

    assign value_o = gen_q;

    // R4
    gen_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        value_o != '0);

    // R6
    gen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !load_i) |=> $stable(value_o));
endmodule

// File: rtl/pbit_lut.sv
module pbit_lut #(
    parameter int            AW   = 6,
    parameter int            DW   = 8,
    parameter logic [DW-1:0] INIT = 8'h80
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          loc_we_i,
    input  logic [AW-1:0] loc_idx_i,
    input  logic [DW-1:0] loc_data_i,
    input  logic          bc_we_i,
    input  logic [AW-1:0] bc_idx_i,
    input  logic [DW-1:0] bc_data_i,
    input  logic [AW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] tab_d [DEPTH];
    logic [DW-1:0] tab_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            tab_d[i] = tab_q[i];
            if (bc_we_i  && bc_idx_i  == AW'(i)) tab_d[i] = bc_data_i;
            if (loc_we_i && loc_idx_i == AW'(i)) tab_d[i] = loc_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= INIT;
        end else begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= tab_d[i];
        end
    end

    assign rd_data_o = tab_q[rd_idx_i];

    // R7
    lut_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bc_we_i && !(loc_we_i && loc_idx_i == bc_idx_i))
        |=> tab_q[$past(bc_idx_i)] == $past(bc_data_i));

    // R7
    lut_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        loc_we_i |=> tab_q[$past(loc_idx_i)] == $past(loc_data_i));
endmodule

// File: rtl/pbit_cell.sv
module pbit_cell
    import pbit_pkg::*;
#(
    parameter int NNB    = 4,
    parameter int WGT_W  = 4,
    parameter int BIAS_W = 6,
    parameter int BETA_W = 4,
    parameter int IDX_W  = 6,
    parameter int LUT_DW = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [NNB-1:0]    nb_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              bc_en_i,
    input  logic [IDX_W-1:0]  bc_idx_i,
    input  logic [LUT_DW-1:0] bc_data_i,
    output logic              state_o
);
    localparam logic [ADDR_W-1:0] A_BIAS = ADDR_W'(REG_BIAS);
    localparam logic [ADDR_W-1:0] A_BETA = ADDR_W'(REG_BETA);
    localparam logic [ADDR_W-1:0] A_ATT  = ADDR_W'(REG_ATT);
    localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(REG_PER);
    localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(REG_SEED);
    localparam int                HI_W   = ADDR_W - IDX_W;
    localparam logic [BETA_W-1:0] BETA_ONE = BETA_W'(4);

    typedef struct packed {
        logic                   state;
        logic [CNT_W-1:0]       cnt;
        logic [NNB*WGT_W-1:0]   wgt;
        logic [BIAS_W-1:0]      bias;
        logic [BETA_W-1:0]      beta;
        logic [LUT_DW-1:0]      att;
        logic [CNT_W-1:0]       per;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0]  idx;
    logic [LUT_DW-1:0] act;
    logic [GEN_W-1:0]  gen;
    logic [CNT_W-1:0]  per_m1;
    logic              fire;
    logic              attempt;
    logic              seed_we;
    logic              lut_we;
    logic [LUT_DW-1:0] rnd_cmp;
    logic [LUT_DW-1:0] rnd_att;

    pbit_synapse #(
        .NNB(NNB), .WGT_W(WGT_W), .BIAS_W(BIAS_W), .BETA_W(BETA_W),
        .BETA_FRAC(2), .IDX_W(IDX_W)
    ) u_syn (
        .nb_i(nb_i), .wgt_i(ctl_q.wgt), .bias_i(ctl_q.bias),
        .beta_i(ctl_q.beta), .idx_o(idx)
    );

    assign lut_we  = wr_en_i && (wr_addr_i[ADDR_W-1:IDX_W] == HI_W'(1));
    assign seed_we = wr_en_i && (wr_addr_i == A_SEED);

    pbit_lut #(.AW(IDX_W), .DW(LUT_DW), .INIT(LUT_DW'(1) << (LUT_DW - 1))) u_lut (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .loc_we_i(lut_we), .loc_idx_i(wr_addr_i[IDX_W-1:0]),
        .loc_data_i(wr_data_i[LUT_DW-1:0]),
        .bc_we_i(bc_en_i), .bc_idx_i(bc_idx_i), .bc_data_i(bc_data_i),
        .rd_idx_i(idx), .rd_data_o(act)
    );

    pbit_lfsr u_gen (
        .clk_i(clk_i), .rst_ni(rst_ni), .step_i(fire), .load_i(seed_we),
        .seed_i(wr_data_i[GEN_W-1:0]), .value_o(gen)
    );

    assign rnd_cmp = gen[LUT_DW-1:0];
    assign rnd_att = gen[2*LUT_DW-1:LUT_DW];
    assign per_m1  = (ctl_q.per == '0) ? '0 : ctl_q.per - CNT_W'(1);
    assign fire    = run_i && (ctl_q.cnt >= per_m1);
    assign attempt = (rnd_att <= ctl_q.att);

    always_comb begin
        ctl_d = ctl_q;
        if (run_i) begin
            if (fire) begin
                ctl_d.cnt = '0;
                if (attempt) ctl_d.state = (rnd_cmp < act);
            end else begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
            end
        end
        if (wr_en_i) begin
            for (int k = 0; k < NNB; k++) begin
                if (wr_addr_i == ADDR_W'(REG_WGT0) + ADDR_W'(k))
                    ctl_d.wgt[k*WGT_W +: WGT_W] = wr_data_i[WGT_W-1:0];
            end
            if (wr_addr_i == A_BIAS) ctl_d.bias = wr_data_i[BIAS_W-1:0];
            if (wr_addr_i == A_BETA) ctl_d.beta = wr_data_i[BETA_W-1:0];
            if (wr_addr_i == A_ATT)  ctl_d.att  = wr_data_i[LUT_DW-1:0];
            if (wr_addr_i == A_PER)  ctl_d.per  = wr_data_i[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q       <= '0;
            ctl_q.beta  <= BETA_ONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o = ctl_q.state;

    // R6
    pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> ($stable(state_o) && $stable(ctl_q.cnt)));

    // R3
    upd_on_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fire |=> $stable(state_o));

    // R5
    cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire |=> (ctl_q.cnt == '0));

    // R3
    no_attempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && !attempt) |=> $stable(state_o));
endmodule

// File: tb/pbit_cell_tb.sv
module pbit_cell_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [3:0]  nb = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        bc_en = 1'b0;
    logic [5:0]  bc_idx = '0;
    logic [7:0]  bc_data = '0;
    logic        state;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    // model
    int          mw [4];
    int          mb, mbeta, matt, mper, mcnt;
    int          mlut [64];
    logic [31:0] mgen;
    logic        mstate;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbit_cell u_dut (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .nb_i(nb),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .bc_en_i(bc_en), .bc_idx_i(bc_idx), .bc_data_i(bc_data),
        .state_o(state)
    );

    function automatic logic [31:0] m_step(input logic [31:0] s);
        logic [31:0] r;
        r = {1'b0, s[31:1]};
        if (s[0]) r = r ^ 32'h80200003;
        return r;
    endfunction

    function automatic int m_index();
        int s;
        s = mb;
        for (int k = 0; k < 4; k++) s = nb[k] ? s + mw[k] : s - mw[k];
        s = (s * mbeta) >>> 2;
        if (s > 31) s = 31;
        if (s < -32) s = -32;
        return s + 32;
    endfunction

    task automatic m_reset();
        for (int k = 0; k < 4; k++) mw[k] = 0;
        mb = 0; mbeta = 4; matt = 0; mper = 0; mcnt = 0;
        for (int i = 0; i < 64; i++) mlut[i] = 128;
        mgen = 32'h1D872B41;
        mstate = 1'b0;
    endtask

    task automatic m_eval();
        int pm1;
        int idx;
        logic [31:0] g;
        g = mgen;
        pm1 = (mper == 0) ? 0 : mper - 1;
        if (run) begin
            if (mcnt >= pm1) begin
                idx = m_index();
                if (int'(g[15:8]) <= matt) mstate = (int'(g[7:0]) < mlut[idx]);
                mcnt = 0;
                mgen = m_step(g);
            end else begin
                mcnt = mcnt + 1;
            end
        end
        if (bc_en) mlut[bc_idx] = int'(bc_data);
        if (wr_en) begin
            if (wr_addr < 8'h04) mw[wr_addr] = int'($signed(wr_data[3:0]));
            if (wr_addr == 8'h08) mb    = int'($signed(wr_data[5:0]));
            if (wr_addr == 8'h09) mbeta = int'(wr_data[3:0]);
            if (wr_addr == 8'h0A) matt  = int'(wr_data[7:0]);
            if (wr_addr == 8'h0B) mper  = int'(wr_data[7:0]);
            if (wr_addr == 8'h0C) mgen  = (wr_data == 32'h0) ? 32'h1D872B41 : wr_data;
            if (wr_addr[7:6] == 2'b01) mlut[wr_addr[5:0]] = int'(wr_data[7:0]);
        end
    endtask

    task automatic check_state();
        checks++;
        if (state !== mstate) begin
            fails++;
            $display("FAIL %s: state actual=%0b expected=%0b at %0t", tag, state, mstate, $time);
        end
    endtask

    task automatic tick();
        m_eval();
        @(posedge clk);
        #1;
        check_state();
        wr_en = 1'b0;
        bc_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_reset();
        repeat (3) @(posedge clk);
        #1;
        check_state();              // R1 reset state
        rst_n = 1'b1;

        // R1: defaults drive decisions (table 0x80, seed constant, threshold 0)
        tag = "R1";
        run = 1'b1;
        ticks(300);

        // R8/R2: saturation high, strong positive
        tag = "R2";
        for (int k = 0; k < 4; k++) wr(8'(k), 32'h7);
        wr(8'h08, 32'h1F);
        wr(8'h09, 32'hF);
        wr(8'h0A, 32'hFF);
        for (int i = 0; i < 64; i++) wr(8'h40 + 8'(i), (i == 63) ? 32'hFF : 32'h0);
        nb = 4'hF;
        ticks(40);
        // saturation low
        for (int k = 0; k < 4; k++) wr(8'(k), 32'h8);
        wr(8'h08, 32'h20);
        wr(8'h40, 32'hFF);
        wr(8'h7F, 32'h00);
        nb = 4'hF;
        ticks(40);
        nb = 4'h0;
        ticks(40);

        // R4: zero seed guard, seed on a decision cycle
        tag = "R4";
        wr(8'h0C, 32'h0);
        ticks(30);
        wr(8'h0C, 32'hDEADBEEF);
        ticks(30);

        // R7: broadcast versus local on same entry
        tag = "R7";
        for (int k = 0; k < 4; k++) wr(8'(k), 32'h0);
        wr(8'h08, 32'h0);
        nb = 4'h0;                  // index 32
        bc_en = 1'b1; bc_idx = 6'd32; bc_data = 8'h00;
        wr(8'h60, 32'hFF);          // local wins
        ticks(30);
        bc_en = 1'b1; bc_idx = 6'd32; bc_data = 8'h00;
        tick();
        ticks(30);
        for (int i = 0; i < 64; i++) begin
            bc_en = 1'b1; bc_idx = 6'(i); bc_data = 8'(i * 4);
            tick();
        end

        // R5: periods
        tag = "R5";
        wr(8'h0B, 32'd0);
        ticks(20);
        wr(8'h0B, 32'd7);
        ticks(50);
        wr(8'h0B, 32'd2);
        ticks(20);

        // R6: pause mid period, writes still land
        tag = "R6";
        wr(8'h0B, 32'd5);
        ticks(3);
        run = 1'b0;
        ticks(10);
        wr(8'h0A, 32'hFF);
        wr(8'h0C, 32'h0000_1357);
        ticks(5);
        run = 1'b1;
        ticks(30);

        // R3: constrained random
        tag = "R3";
        for (int n = 0; n < 4000; n++) begin
            nb  = 4'($urandom);
            run = ($urandom_range(0, 9) != 0);
            case ($urandom_range(0, 11))
                0: begin wr_en = 1'b1; wr_addr = 8'($urandom_range(0, 3)); wr_data = $urandom; end
                1: begin wr_en = 1'b1; wr_addr = 8'h08; wr_data = $urandom; end
                2: begin wr_en = 1'b1; wr_addr = 8'h09; wr_data = $urandom; end
                3: begin wr_en = 1'b1; wr_addr = 8'h0A; wr_data = $urandom; end
                4: begin wr_en = 1'b1; wr_addr = 8'h0B; wr_data = 32'($urandom_range(0, 4)); end
                5: begin wr_en = 1'b1; wr_addr = 8'h0C; wr_data = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom; end
                6: begin wr_en = 1'b1; wr_addr = 8'h40 + 8'($urandom_range(0, 63)); wr_data = $urandom; end
                7: begin bc_en = 1'b1; bc_idx = 6'($urandom); bc_data = 8'($urandom); end
                default: ;
            endcase
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule